// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which hardware interrupt a microprogrammed processor should service next. There are four service levels, numbered 0 (most urgent) to 3 (least urgent), plus the main program level that runs when nothing is being serviced. A request at a level more urgent than the one now running preempts it. The interrupted level is remembered in an active-level mask and resumes once the microcode signals that the preempting routine is done.

Level 0 gathers several machine-check causes. Level 1 has a single disk-attention request. Level 2 is shared by a communications adapter, a keyboard and a printer, which are ranked in that fixed order. Level 3 gathers the optional feature attachments. Each grant produces a one-cycle strobe that carries the new level code and a sub-source code naming the winning cause inside that level.

All pins are plain control and status signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. Requests are level-sensitive and are sampled on every rising clock edge. A device holds its request until its own routine clears it.

Top module: `nested_irq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the mask is cleared. After that edge `cur_level_o` reads 7 (main program level), `active_mask_o` reads 0 and `take_o` reads 0.
- R2: A request sampled at edge t that is more urgent than the current level produces a grant at that edge. From edge t on, `take_o` is 1 and `take_level_o` holds the level code (0 to 3). The level's bit (bit n for level n) is set in `active_mask_o`, and `cur_level_o` equals the granted level.
- R3: When several levels request at once, the lowest-numbered level wins.
- R4: A request at a level numerically lower than the active level preempts it. The new grant nests on top, and both mask bits are set.
- R5: A request at the same level as, or a numerically higher level than, the active one produces no grant. It stays pending until the active level exits.
- R6: `exit_i` high at an edge clears the mask bit of the current level. The current level then becomes the lowest-numbered remaining set bit, or 7 if none is left. No grant happens at an edge where `exit_i` is high.
- R7: `exit_i` at the main program level (mask 0) has no effect: the mask stays 0 and no grant occurs.
- R8: Level 0 is requested when any bit of `mc_cause_i` is set. Its sub-source code is the lowest-numbered set cause bit.
- R9: Level 2 ranks its sources by bit: bit 0 is the communications adapter (sub code 0), bit 1 is the keyboard (sub code 1) and bit 2 is the printer (sub code 2). The lowest set bit wins.
- R10: Level 3 is requested when any bit of `opt_req_i` is set, and its sub code is the lowest set bit. Level 1 always reports sub code 0.
- R11: `take_o` is a one-cycle pulse. It is high in a second consecutive cycle only for a further grant at a strictly more urgent level.
- R12: The reserved level codes 4 and 5 never appear on `take_level_o` or `cur_level_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_cause_i | input | NUM_MC | Machine-check causes (level 0) |
| disk_req_i | input | 1 | Disk attention (level 1) |
| shared_req_i | input | 3 | Level 2 sources: bit0 comms, bit1 keyboard, bit2 printer |
| opt_req_i | input | NUM_OPT | Optional feature attachments (level 3) |
| exit_i | input | 1 | Retire the current level |
| take_o | output | 1 | One-cycle grant strobe |
| take_level_o | output | 3 | Level code of the grant |
| take_sub_o | output | SUB_W | Sub-source code of the grant |
| cur_level_o | output | 3 | Current level, 7 for main program |
| active_mask_o | output | 4 | Nesting mask, bit n = level n active |

## Verification
The assertions check the following on every cycle:
- each grant lands on a level more urgent than the one it interrupted, and that level becomes current;
- no grant coincides with an exit;
- an exit removes exactly one mask bit, or none when the mask is empty;
- reserved codes never surface;
- the reported sub-source is really asserted and is the top-ranked one.

Only the bench scenarios can show that the winning level and sub code are correct for every combination of requests. The same goes for whether a deferred request is granted once the blocking level retires, and whether nested exits unwind in the right order.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = 3;
  localparam logic [LVL_W-1:0] MAIN_LVL = 3'd7;
  localparam int NUM_SHARED = 3;

  function automatic int sub_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    if (NUM_SHARED > m) m = NUM_SHARED;
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    valid = |req;
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NUM_MC  = 4,
  parameter int NUM_OPT = 3,
  parameter int SUB_W   = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_MC-1:0]                     mc_cause,
  input  logic                                  disk_req,
  input  logic [nic_pkg::NUM_SHARED-1:0]        shared_req,
  input  logic [NUM_OPT-1:0]                    opt_req,
  output logic [nic_pkg::NUM_LVL-1:0]           pend,
  output logic [nic_pkg::NUM_LVL-1:0][SUB_W-1:0] sub_by_lvl
);
  logic            mc_v, sh_v, op_v;
  logic [SUB_W-1:0] mc_idx, sh_idx, op_idx;

  nic_prio_pick #(.W(NUM_MC), .IW(SUB_W)) u_mc_pick (
    .req(mc_cause), .valid(mc_v), .idx(mc_idx));
  nic_prio_pick #(.W(nic_pkg::NUM_SHARED), .IW(SUB_W)) u_sh_pick (
    .req(shared_req), .valid(sh_v), .idx(sh_idx));
  nic_prio_pick #(.W(NUM_OPT), .IW(SUB_W)) u_op_pick (
    .req(opt_req), .valid(op_v), .idx(op_idx));

  always_comb begin
    pend          = {op_v, sh_v, disk_req, mc_v};
    sub_by_lvl[0] = mc_idx;
    sub_by_lvl[1] = '0;
    sub_by_lvl[2] = sh_idx;
    sub_by_lvl[3] = op_idx;
  end

  // machine-check sub code names a cause that is really raised
  assert_mc_cause_R8: assert property (@(posedge clk) disable iff (rst)
    pend[0] |-> mc_cause[mc_idx]);
  // shared level respects comms > keyboard > printer
  assert_shared_order_R9: assert property (@(posedge clk) disable iff (rst)
    pend[2] |-> (shared_req[sh_idx] && (sh_idx == '0 || !shared_req[0])
                 && (sh_idx != SUB_W'(2) || !shared_req[1])));
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [1:0]                    push_lvl,
  input  logic                          exit_i,
  output logic [nic_pkg::NUM_LVL-1:0]   mask,
  output logic                          busy,
  output logic [nic_pkg::LVL_W-1:0]     cur_code
);
  import nic_pkg::*;
  logic [NUM_LVL-1:0] mask_q;
  logic [1:0]         top_idx;
  logic               top_v;

  nic_prio_pick #(.W(NUM_LVL), .IW(2)) u_top_pick (
    .req(mask_q), .valid(top_v), .idx(top_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (exit_i) begin
      if (top_v) mask_q[top_idx] <= 1'b0;
    end else if (push) begin
      mask_q[push_lvl] <= 1'b1;
    end
  end

  always_comb begin
    mask     = mask_q;
    busy     = top_v;
    cur_code = top_v ? {1'b0, top_idx} : MAIN_LVL;
  end

  assert_exit_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (exit_i && mask_q != '0) |=> ($countones(mask_q) + 1 == $countones($past(mask_q))));
  assert_exit_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (exit_i && mask_q == '0) |=> (mask_q == '0));
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int NUM_MC  = 4,
  parameter int NUM_OPT = 3,
  parameter int SUB_W   = nic_pkg::sub_width(NUM_MC, NUM_OPT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MC-1:0]      mc_cause_i,
  input  logic                   disk_req_i,
  input  logic [2:0]             shared_req_i,
  input  logic [NUM_OPT-1:0]     opt_req_i,
  input  logic                   exit_i,
  output logic                   take_o,
  output logic [2:0]             take_level_o,
  output logic [SUB_W-1:0]       take_sub_o,
  output logic [2:0]             cur_level_o,
  output logic [3:0]             active_mask_o
);
  import nic_pkg::*;
  localparam int RANK_W = LVL_W;

  logic [NUM_LVL-1:0]            pend, above, eligible;
  logic [NUM_LVL-1:0][SUB_W-1:0] sub_by_lvl;
  logic                          busy, win_v, grant;
  logic [1:0]                    win_idx;
  logic [LVL_W-1:0]              cur_code;
  logic [RANK_W-1:0]             cur_rank;
  logic                          take_q;
  logic [2:0]                    take_lvl_q;
  logic [SUB_W-1:0]              take_sub_q;

  nic_arbiter #(.NUM_MC(NUM_MC), .NUM_OPT(NUM_OPT), .SUB_W(SUB_W)) u_arb (
    .clk(clk), .rst(rst), .mc_cause(mc_cause_i), .disk_req(disk_req_i),
    .shared_req(shared_req_i), .opt_req(opt_req_i),
    .pend(pend), .sub_by_lvl(sub_by_lvl));

  // main program level ranks below every service level
  always_comb begin
    cur_rank = busy ? cur_code : RANK_W'(NUM_LVL);
    for (int i = 0; i < NUM_LVL; i++) above[i] = (RANK_W'(i) < cur_rank);
    eligible = pend & above;
  end

  nic_prio_pick #(.W(NUM_LVL), .IW(2)) u_lvl_pick (
    .req(eligible), .valid(win_v), .idx(win_idx));

  assign grant = win_v && !exit_i;

  nic_level_stack u_stack (
    .clk(clk), .rst(rst), .push(grant), .push_lvl(win_idx), .exit_i(exit_i),
    .mask(active_mask_o), .busy(busy), .cur_code(cur_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q     <= 1'b0;
      take_lvl_q <= '0;
      take_sub_q <= '0;
    end else begin
      take_q <= grant;
      if (grant) begin
        take_lvl_q <= {1'b0, win_idx};
        take_sub_q <= sub_by_lvl[win_idx];
      end
    end
  end

  assign take_o       = take_q;
  assign take_level_o = take_lvl_q;
  assign take_sub_o   = take_sub_q;
  assign cur_level_o  = cur_code;

  assert_take_current_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (take_level_o == cur_level_o));
  assert_no_lower_grant_R5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ($past(active_mask_o) == '0 || take_level_o < $past(cur_level_o)));
  assert_no_take_on_exit_R6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !$past(exit_i));
  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (!take_o || take_level_o < $past(take_level_o)));
  assert_legal_code_R12: assert property (@(posedge clk) disable iff (rst)
    (cur_level_o < 3'd4 || cur_level_o == 3'd7) && (!take_o || take_level_o < 3'd4));
endmodule

// File: tb/nested_irq_ctrl_test.sv
module nested_irq_ctrl_test;
  localparam int NUM_MC = 4, NUM_OPT = 3, SUB_W = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic [NUM_MC-1:0] mc = '0;
  logic disk = 1'b0;
  logic [2:0] sh = '0;
  logic [NUM_OPT-1:0] opt = '0;
  logic ex = 1'b0;
  logic take;
  logic [2:0] tlvl, cur;
  logic [SUB_W-1:0] tsub;
  logic [3:0] amask;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nested_irq_ctrl #(.NUM_MC(NUM_MC), .NUM_OPT(NUM_OPT)) uut (
    .clk(clk), .rst(rst), .mc_cause_i(mc), .disk_req_i(disk), .shared_req_i(sh),
    .opt_req_i(opt), .exit_i(ex), .take_o(take), .take_level_o(tlvl),
    .take_sub_o(tsub), .cur_level_o(cur), .active_mask_o(amask));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int low_bit(input int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic clear_req();
    mc = '0; disk = 0; sh = '0; opt = '0;
  endtask

  task automatic raise(input int lvl);
    case (lvl)
      0: mc[0] = 1'b1;
      1: disk = 1'b1;
      2: sh[0] = 1'b1;
      default: opt[0] = 1'b1;
    endcase
  endtask

  task automatic do_exit();
    ex = 1'b1; step(); ex = 1'b0;
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    chk("R1 cur after reset", cur, 7);
    chk("R1 mask after reset", amask, 0);
    chk("R1 take after reset", take, 0);

    // R7: exit at main level does nothing
    do_exit();
    chk("R7 mask stays empty", amask, 0);
    chk("R7 no take on idle exit", take, 0);

    // exhaustive sweep from main level: R2 R3 R8 R9 R10 R11
    for (int p = 0; p < 2048; p++) begin
      int pm, pd, ps, po, el, es;
      pm = p & 15; pd = (p >> 4) & 1; ps = (p >> 5) & 7; po = (p >> 8) & 7;
      mc = pm[3:0]; disk = pd[0]; sh = ps[2:0]; opt = po[2:0];
      if (pm != 0) begin el = 0; es = low_bit(pm); end
      else if (pd != 0) begin el = 1; es = 0; end
      else if (ps != 0) begin el = 2; es = low_bit(ps); end
      else if (po != 0) begin el = 3; es = low_bit(po); end
      else begin el = 7; es = 0; end
      step();
      if (el == 7) begin
        chk("R2 no take without request", take, 0);
        chk("R2 stays main", cur, 7);
      end else begin
        chk("R3 take strobe", take, 1);
        chk("R3 granted level", tlvl, el);
        chk("R8/R9/R10 sub code", tsub, es);
        chk("R2 current level", cur, el);
        chk("R2 mask bit", amask, 1 << el);
        step();
        chk("R11 strobe falls", take, 0);
        chk("R5 held request not regranted", amask, 1 << el);
        clear_req();
        do_exit();
        chk("R6 back to main", cur, 7);
      end
      clear_req();
    end

    // nesting sweep: R4 R5 R6
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        raise(a); step();
        chk("R2 first grant", cur, a);
        raise(b); step();
        if (b < a) begin
          chk("R4 preempt take", take, 1);
          chk("R4 preempt level", cur, b);
          chk("R4 nested mask", amask, (1 << a) | (1 << b));
        end else begin
          chk("R5 no take", take, 0);
          chk("R5 level kept", cur, a);
        end
        clear_req();
        do_exit();
        if (b < a) begin
          chk("R6 resume interrupted", cur, a);
          do_exit();
        end
        chk("R6 unwound to main", cur, 7);
      end
    end

    // R5/R6: deferred request granted after exit, not at the exit edge
    disk = 1; step();
    sh = 3'b110; step();
    chk("R5 shared deferred", cur, 1);
    ex = 1; step(); ex = 0;
    chk("R6 no grant at exit edge", take, 0);
    chk("R6 main after exit", cur, 7);
    disk = 0; step();
    chk("R5 deferred now granted", tlvl, 2);
    chk("R9 keyboard beats printer", tsub, 1);
    chk("R12 code legal", (cur == 2) ? 1 : 0, 1);
    clear_req(); do_exit();

    // R1: reset while nested
    disk = 1; step(); mc = 4'b1000; step();
    rst = 1; step(); rst = 0; clear_req();
    chk("R1 reset clears mask", amask, 0);
    chk("R1 reset to main", cur, 7);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule